// File: doc/BRIEF.md
# Memory Error Injection Unit

This unit sits beside the write path of a memory controller and corrupts chosen bits of outgoing codewords on purpose, so that the ECC and parity checking further down the line can be exercised on real hardware. Software programs a target location as a set of decoded DRAM coordinates: channel, DIMM slot within the channel, rank, bank, page and column. Each coordinate can be set to a wildcard instead. Software also programs a corruption mask, which half of the 128-bit codeword to hit, and an error type. It then arms the unit.

While it is armed, the unit checks every decoded access request against the target. One cycle after a request that matches, it presents an XOR mask for the 128 data bits and a parity-flip flag, which the datapath applies to the codeword. A one-shot injection disarms the unit after it fires. A repeating injection corrupts every matching access until software disarms the unit. The unit copies its configuration when it is armed, so software can reprogram the registers at any time without changing an injection that is already running.

Top module: `mem_err_inject`

## Requirements
- R1: After reset, each of the six coordinate registers (addresses 0 to 5: channel, DIMM, rank, bank, page, column) reads back with its wildcard bit 31 set and a value of 0. The mask (address 6), the type (address 8), the enable (address 9) and the read-match flag (address 10) read 0. The section code (address 7) reads 3.
- R2: Each configuration register reads back what was written to it. A coordinate value is cut to the width of its field (channel, DIMM and rank 2 bits, bank 3, page 16, column 12) and keeps its bit 31 wildcard flag.
- R3: When the unit is armed, a valid write request that equals every non-wildcard coordinate sets inj_hit_o in the next cycle. A request that differs in any non-wildcard coordinate does not.
- R4: A request with channel 3 or DIMM 3 never matches, even when every coordinate is a wildcard.
- R5: A read request (req_write_i = 0) matches only if bit 0 of the read-match flag is 1 in the active configuration.
- R6: Section code 1 applies the mask to data bits 63:0, code 2 to bits 127:64, and code 3 to both halves. Code 0 blocks injection.
- R7: In the type register, bit 1 selects ECC mode, which applies the mask. Bit 2 selects parity mode, which sets inj_parity_o and leaves the data XOR at zero, and it takes priority over bit 1. A type with neither bit set blocks injection.
- R8: When type bit 0 (repeat) is clear, the unit disarms after the first injection and the enable register then reads 0. When repeat is set, the unit stays armed and corrupts every matching access.
- R9: Writing a nonzero value to the enable register arms the unit, and the register then reads 1. Writing 0 disarms it. A disarmed unit never injects.
- R10: Arming the unit copies the coordinate, mask, section, type and read-match settings. Registers written while the unit is armed read back their new values, but they take effect only at the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_addr_i | input | 4 | Configuration register address (read and write) |
| cfg_wdata_i | input | 64 | Configuration write data |
| cfg_rdata_o | output | 64 | Configuration read data for cfg_addr_i |
| req_valid_i | input | 1 | Decoded access request present |
| req_write_i | input | 1 | 1 for a write access, 0 for a read access |
| req_chan_i | input | 2 | Request channel |
| req_dimm_i | input | 2 | Request DIMM slot within the channel |
| req_rank_i | input | 2 | Request rank |
| req_bank_i | input | 3 | Request bank |
| req_page_i | input | 16 | Request page (row) |
| req_col_i | input | 12 | Request column |
| inj_hit_o | output | 1 | An injection applies to the request from the previous cycle |
| inj_data_xor_o | output | 128 | XOR mask for the codeword data bits |
| inj_parity_o | output | 1 | Flip the access parity bit |

## Verification
The assertions assume that the configuration port and the request stream are never active in the same cycle. Without that assumption, a one-shot disarm and a software write to the enable register could land on the same edge. The bench always separates register accesses from requests by at least one idle cycle. It checks every request in the cycle after it and predicts the results from a register-level model that copies the settings on arming and changes them only through the configuration port.

// File: rtl/mei_pkg.sv
package mei_pkg;
  localparam int NF       = 6;   // match coordinates
  localparam int FW       = 16;  // storage width per coordinate
  localparam int WILD_BIT = 31;
  localparam int NSEC     = 2;   // codeword halves

  typedef enum logic [3:0] {
    A_CHAN = 4'd0, A_DIMM = 4'd1, A_RANK = 4'd2, A_BANK = 4'd3,
    A_PAGE = 4'd4, A_COL  = 4'd5, A_MASK = 4'd6, A_SECT = 4'd7,
    A_TYPE = 4'd8, A_ENAB = 4'd9, A_RDEN = 4'd10
  } cfg_addr_e;

  typedef struct packed {
    logic [NF-1:0]         wild;
    logic [NF-1:0][FW-1:0] val;
    logic [1:0]            sect;
    logic [2:0]            typ;   // [0] repeat, [1] ecc, [2] parity
    logic                  rd;
  } act_cfg_t;
endpackage

// File: rtl/mei_cfg_regs.sv
module mei_cfg_regs
  import mei_pkg::*;
#(
  parameter int CFG_W  = 64,
  parameter int CH_W   = 2,
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  input  logic             fire_i,
  output act_cfg_t         act_o,
  output logic [CFG_W-1:0] act_mask_o,
  output logic             armed_o
);
  localparam int FW_TBL [NF] = '{CH_W, DIMM_W, RANK_W, BANK_W, PAGE_W, COL_W};

  logic [FW-1:0]    fmask  [NF];
  logic [FW-1:0]    val_q  [NF];
  logic [NF-1:0]    wild_q;
  logic [CFG_W-1:0] fld_rd [NF];
  logic [CFG_W-1:0] mask_q, act_mask_q;
  logic [1:0]       sect_q;
  logic [2:0]       type_q;
  logic             rden_q, armed_q;
  act_cfg_t         prog, act_q;
  logic             arm_wr;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fmask[g]  = FW'((32'd1 << FW_TBL[g]) - 32'd1);
    assign fld_rd[g] = CFG_W'(val_q[g]) | (CFG_W'(wild_q[g]) << WILD_BIT);
    assign prog.val[g] = val_q[g];
  end

  assign prog.wild = wild_q;
  assign prog.sect = sect_q;
  assign prog.typ  = type_q;
  assign prog.rd   = rden_q;

  assign arm_wr = we_i && (addr_i == A_ENAB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NF; i++) val_q[i] <= '0;
      wild_q <= '1;
      mask_q <= '0;
      sect_q <= 2'd3;
      type_q <= '0;
      rden_q <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < NF; i++) begin
        if (addr_i == 4'(i)) begin
          val_q[i]  <= wdata_i[FW-1:0] & fmask[i];
          wild_q[i] <= wdata_i[WILD_BIT];
        end
      end
      if (addr_i == A_MASK) mask_q <= wdata_i;
      if (addr_i == A_SECT) sect_q <= wdata_i[1:0];
      if (addr_i == A_TYPE) type_q <= wdata_i[2:0];
      if (addr_i == A_RDEN) rden_q <= wdata_i[0];
    end
  end

  // arming copies the programmed settings; software write wins over one-shot clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      act_q      <= '0;
      act_mask_q <= '0;
    end else if (arm_wr) begin
      if (|wdata_i) begin
        if (!armed_q) begin
          armed_q    <= 1'b1;
          act_q      <= prog;
          act_mask_q <= mask_q;
        end
      end else begin
        armed_q <= 1'b0;
      end
    end else if (fire_i && !act_q.typ[0]) begin
      armed_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NF; i++) if (addr_i == 4'(i)) rdata_o = fld_rd[i];
    case (addr_i)
      A_MASK:  rdata_o = mask_q;
      A_SECT:  rdata_o = CFG_W'(sect_q);
      A_TYPE:  rdata_o = CFG_W'(type_q);
      A_ENAB:  rdata_o = CFG_W'(armed_q);
      A_RDEN:  rdata_o = CFG_W'(rden_q);
      default: ;
    endcase
  end

  assign act_o      = act_q;
  assign act_mask_o = act_mask_q;
  assign armed_o    = armed_q;

  AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !act_q.typ[0] && !arm_wr) |=> !armed_q); // R8
  AST_REPEAT_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && act_q.typ[0] && !arm_wr) |=> armed_q); // R8
  AST_SNAPSHOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ($stable(act_q) && $stable(act_mask_q))); // R10
  AST_FIRE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> armed_q); // R9
endmodule

// File: rtl/mei_addr_match.sv
module mei_addr_match
  import mei_pkg::*;
#(
  parameter int CH_W     = 2,
  parameter int DIMM_W   = 2,
  parameter int NUM_CH   = 3,
  parameter int NUM_DIMM = 3
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [NF-1:0][FW-1:0] req_i,
  input  act_cfg_t          act_i,
  output logic              match_o
);
  logic [NF-1:0] fld_ok;
  logic          coord_ok, dir_ok;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign fld_ok[g] = act_i.wild[g] || (req_i[g] == act_i.val[g]);
  end

  // coordinate 0 is channel, 1 is DIMM
  assign coord_ok = (req_i[0] < FW'(NUM_CH)) && (req_i[1] < FW'(NUM_DIMM));
  assign dir_ok   = write_i || act_i.rd;
  assign match_o  = valid_i && coord_ok && dir_ok && (&fld_ok);
endmodule

// File: rtl/mei_xor_gen.sv
module mei_xor_gen
  import mei_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fire_i,
  input  logic [1:0]             sect_i,
  input  logic                   par_i,
  input  logic [HALF_W-1:0]      mask_i,
  output logic                   hit_o,
  output logic [NSEC*HALF_W-1:0] data_xor_o,
  output logic                   parity_o
);
  logic [NSEC*HALF_W-1:0] half_x;

  for (genvar h = 0; h < NSEC; h++) begin : g_half
    assign half_x[h*HALF_W +: HALF_W] = (sect_i[h] && !par_i) ? mask_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      data_xor_o <= '0;
      parity_o   <= 1'b0;
    end else begin
      hit_o      <= fire_i;
      data_xor_o <= fire_i ? half_x : '0;
      parity_o   <= fire_i && par_i;
    end
  end

  AST_PARITY_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_o |-> (data_xor_o == '0)); // R7
  AST_QUIET_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> ((data_xor_o == '0) && !parity_o)); // R3
endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject
  import mei_pkg::*;
#(
  parameter int CH_W     = 2,
  parameter int DIMM_W   = 2,
  parameter int RANK_W   = 2,
  parameter int BANK_W   = 3,
  parameter int PAGE_W   = 16,
  parameter int COL_W    = 12,
  parameter int NUM_CH   = 3,
  parameter int NUM_DIMM = 3,
  parameter int HALF_W   = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [3:0]             cfg_addr_i,
  input  logic [HALF_W-1:0]      cfg_wdata_i,
  output logic [HALF_W-1:0]      cfg_rdata_o,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [CH_W-1:0]        req_chan_i,
  input  logic [DIMM_W-1:0]      req_dimm_i,
  input  logic [RANK_W-1:0]      req_rank_i,
  input  logic [BANK_W-1:0]      req_bank_i,
  input  logic [PAGE_W-1:0]      req_page_i,
  input  logic [COL_W-1:0]       req_col_i,
  output logic                   inj_hit_o,
  output logic [NSEC*HALF_W-1:0] inj_data_xor_o,
  output logic                   inj_parity_o
);
  act_cfg_t              act;
  logic [HALF_W-1:0]     act_mask;
  logic                  armed, match, fire;
  logic [NF-1:0][FW-1:0] req_vec;

  assign req_vec[0] = FW'(req_chan_i);
  assign req_vec[1] = FW'(req_dimm_i);
  assign req_vec[2] = FW'(req_rank_i);
  assign req_vec[3] = FW'(req_bank_i);
  assign req_vec[4] = FW'(req_page_i);
  assign req_vec[5] = FW'(req_col_i);

  mei_cfg_regs #(
    .CFG_W(HALF_W), .CH_W(CH_W), .DIMM_W(DIMM_W), .RANK_W(RANK_W),
    .BANK_W(BANK_W), .PAGE_W(PAGE_W), .COL_W(COL_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .fire_i(fire),
    .act_o(act), .act_mask_o(act_mask), .armed_o(armed)
  );

  mei_addr_match #(
    .CH_W(CH_W), .DIMM_W(DIMM_W), .NUM_CH(NUM_CH), .NUM_DIMM(NUM_DIMM)
  ) u_match (
    .valid_i(req_valid_i), .write_i(req_write_i), .req_i(req_vec),
    .act_i(act), .match_o(match)
  );

  assign fire = armed && match && (act.sect != 2'd0) && (act.typ[1] || act.typ[2]);

  mei_xor_gen #(.HALF_W(HALF_W)) u_xor (
    .clk_i, .rst_ni, .fire_i(fire), .sect_i(act.sect), .par_i(act.typ[2]),
    .mask_i(act_mask), .hit_o(inj_hit_o), .data_xor_o(inj_data_xor_o),
    .parity_o(inj_parity_o)
  );

  AST_DISARMED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> !inj_hit_o); // R9
  AST_BAD_COORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ((req_chan_i >= CH_W'(NUM_CH)) || (req_dimm_i >= DIMM_W'(NUM_DIMM))))
    |=> !inj_hit_o); // R4
  AST_READ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !act.rd) |=> !inj_hit_o); // R5
  AST_SECT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.sect == 2'd0) |=> !inj_hit_o); // R6
  AST_NO_REQ_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !inj_hit_o); // R3
endmodule

// File: tb/mem_err_inject_test.sv
module mem_err_inject_test;
  localparam int CLK_P = 10;

  typedef struct {
    bit           hit;
    logic [127:0] x;
    bit           p;
    string        tag;
  } exp_t;

  logic         clk = 0, rst_n = 0;
  logic         cfg_we = 0;
  logic [3:0]   cfg_addr = 0;
  logic [63:0]  cfg_wdata = 0, cfg_rdata;
  logic         req_valid = 0, req_write = 0;
  logic [1:0]   req_chan = 0, req_dimm = 0, req_rank = 0;
  logic [2:0]   req_bank = 0;
  logic [15:0]  req_page = 0;
  logic [11:0]  req_col = 0;
  logic         hit, par;
  logic [127:0] dx;

  int checks = 0, errors = 0;
  bit done = 0, chk_due = 0;
  exp_t q[$];

  // bench model
  int           fw [6] = '{2, 2, 2, 3, 16, 12};
  logic [15:0]  m_val [6];
  bit           m_wild [6];
  logic [63:0]  m_mask = 0, a_mask = 0;
  logic [1:0]   m_sect = 3, a_sect = 0;
  logic [2:0]   m_type = 0, a_type = 0;
  bit           m_rd = 0, a_rd = 0, armed = 0;
  logic [15:0]  a_val [6];
  bit           a_wild [6];

  always #(CLK_P/2) clk = ~clk;

  mem_err_inject uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_chan_i(req_chan), .req_dimm_i(req_dimm), .req_rank_i(req_rank),
    .req_bank_i(req_bank), .req_page_i(req_page), .req_col_i(req_col),
    .inj_hit_o(hit), .inj_data_xor_o(dx), .inj_parity_o(par)
  );

  // monitor
  always @(posedge clk) chk_due <= req_valid;
  always @(negedge clk) begin
    if (chk_due) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL monitor: no expected item, hit=%0d", hit);
      end else begin
        e = q.pop_front();
        if (hit !== e.hit || dx !== e.x || par !== e.p) begin
          errors++;
          $display("FAIL %s: got hit=%0d x=%h p=%0d exp hit=%0d x=%h p=%0d",
                   e.tag, hit, dx, par, e.hit, e.x, e.p);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic cfg_wr(int a, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 6) begin
      m_val[a]  = d[15:0] & 16'((32'd1 << fw[a]) - 1);
      m_wild[a] = d[31];
    end else if (a == 6) m_mask = d;
    else if (a == 7) m_sect = d[1:0];
    else if (a == 8) m_type = d[2:0];
    else if (a == 10) m_rd = d[0];
    else if (a == 9) begin
      if (d != 0) begin
        if (!armed) begin
          armed = 1; a_mask = m_mask; a_sect = m_sect; a_type = m_type; a_rd = m_rd;
          for (int i = 0; i < 6; i++) begin a_val[i] = m_val[i]; a_wild[i] = m_wild[i]; end
        end
      end else armed = 0;
    end
  endtask

  task automatic rd_chk(int a, logic [63:0] exp, string tag);
    @(negedge clk);
    cfg_addr = 4'(a);
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d got %h exp %h", tag, a, cfg_rdata, exp);
    end
  endtask

  function automatic logic [63:0] model_rd(int a);
    if (a < 6) return 64'(m_val[a]) | (64'(m_wild[a]) << 31);
    case (a)
      6: return m_mask;
      7: return 64'(m_sect);
      8: return 64'(m_type);
      9: return 64'(armed);
      default: return 64'(m_rd);
    endcase
  endfunction

  task automatic req(int ch, int dm, int rk, int bk, int pg, int cl, bit wr, string tag);
    exp_t e;
    int   c [6];
    bit   m;
    c = '{ch, dm, rk, bk, pg, cl};
    m = (ch < 3) && (dm < 3) && (wr || a_rd);
    for (int i = 0; i < 6; i++) if (!a_wild[i] && c[i] != int'(a_val[i])) m = 0;
    e.hit = armed && m && (a_sect != 0) && (a_type[1] || a_type[2]);
    e.p   = e.hit && a_type[2];
    e.x   = '0;
    if (e.hit && !a_type[2]) e.x = {a_sect[1] ? a_mask : 64'd0, a_sect[0] ? a_mask : 64'd0};
    e.tag = tag;
    if (e.hit && !a_type[0]) armed = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr;
    req_chan = 2'(ch); req_dimm = 2'(dm); req_rank = 2'(rk);
    req_bank = 3'(bk); req_page = 16'(pg); req_col = 12'(cl);
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic all_any();
    for (int i = 0; i < 6; i++) cfg_wr(i, 64'h8000_0000);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin m_val[i] = 0; m_wild[i] = 1; a_val[i] = 0; a_wild[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int i = 0; i < 6; i++) rd_chk(i, 64'h8000_0000, "R1");
    rd_chk(6, 0, "R1"); rd_chk(7, 3, "R1"); rd_chk(8, 0, "R1");
    rd_chk(9, 0, "R1"); rd_chk(10, 0, "R1");
    // R2 readback and truncation
    cfg_wr(0, 64'h2);          rd_chk(0, model_rd(0), "R2");
    cfg_wr(4, 64'h1_ABCD);     rd_chk(4, 64'hABCD, "R2");
    cfg_wr(5, 64'h8000_FFFF);  rd_chk(5, 64'h8000_0FFF, "R2");
    cfg_wr(6, 64'hDEAD_BEEF_0000_0040); rd_chk(6, model_rd(6), "R2");
    cfg_wr(7, 64'h2);          rd_chk(7, 64'h2, "R2");
    // R9 disarmed: no injection
    all_any(); cfg_wr(6, 64'h40); cfg_wr(7, 3); cfg_wr(8, 3);
    req(0, 0, 0, 0, 0, 0, 1, "R9 disarmed");
    // R3 channel match, repeat ECC, both halves
    cfg_wr(0, 64'h2);
    cfg_wr(9, 64'h5); rd_chk(9, 1, "R9 arm reads 1");
    req(2, 1, 0, 4, 100, 7, 1, "R3 chan hit");
    req(1, 1, 0, 4, 100, 7, 1, "R3 chan miss");
    req(2, 0, 3, 0, 0, 0, 1, "R8 repeat second hit");
    req(2, 1, 0, 4, 100, 7, 0, "R5 read blocked");
    // R10: change while armed has no effect yet
    cfg_wr(10, 1); cfg_wr(6, 64'hF00);
    rd_chk(6, 64'hF00, "R10 readback");
    req(2, 0, 0, 0, 0, 0, 0, "R10 read still blocked");
    req(2, 0, 0, 0, 0, 0, 1, "R10 old mask");
    cfg_wr(9, 0); rd_chk(9, 0, "R9 disarm");
    req(2, 0, 0, 0, 0, 0, 1, "R9 after disarm");
    cfg_wr(9, 1);
    req(2, 2, 1, 1, 9, 9, 0, "R5 read match");
    req(2, 0, 0, 0, 0, 0, 1, "R10 new mask");
    cfg_wr(9, 0);
    // R4 invalid coordinates with all wildcards
    all_any(); cfg_wr(9, 1);
    req(3, 0, 0, 0, 0, 0, 1, "R4 chan3");
    req(0, 3, 0, 0, 0, 0, 1, "R4 dimm3");
    req(0, 2, 3, 7, 65535, 4095, 1, "R3 all wildcard");
    cfg_wr(9, 0);
    // R3 multi-field match
    cfg_wr(1, 1); cfg_wr(2, 2); cfg_wr(3, 5); cfg_wr(4, 16'h1234); cfg_wr(5, 12'h3FF);
    cfg_wr(9, 1);
    req(1, 1, 2, 5, 16'h1234, 12'h3FF, 1, "R3 full hit");
    req(1, 1, 2, 5, 16'h1234, 12'h3FE, 1, "R3 col miss");
    req(1, 1, 2, 4, 16'h1234, 12'h3FF, 1, "R3 bank miss");
    req(1, 0, 2, 5, 16'h1234, 12'h3FF, 1, "R3 dimm miss");
    cfg_wr(9, 0); all_any();
    // R6 sections
    cfg_wr(6, 64'h0123_4567_89AB_CDEF);
    cfg_wr(7, 1); cfg_wr(9, 1); req(0, 0, 0, 0, 0, 0, 1, "R6 lower"); cfg_wr(9, 0);
    cfg_wr(7, 2); cfg_wr(9, 1); req(0, 0, 0, 0, 0, 0, 1, "R6 upper"); cfg_wr(9, 0);
    cfg_wr(7, 0); cfg_wr(9, 1); req(0, 0, 0, 0, 0, 0, 1, "R6 code0"); cfg_wr(9, 0);
    // R7 types
    cfg_wr(7, 3);
    cfg_wr(8, 5); cfg_wr(9, 1); req(1, 1, 1, 1, 1, 1, 1, "R7 parity"); cfg_wr(9, 0);
    cfg_wr(8, 7); cfg_wr(9, 1); req(1, 1, 1, 1, 1, 1, 1, "R7 parity wins"); cfg_wr(9, 0);
    cfg_wr(8, 1); cfg_wr(9, 1); req(1, 1, 1, 1, 1, 1, 1, "R7 no mode");
    rd_chk(9, 1, "R7 still armed"); cfg_wr(9, 0);
    // R8 one-shot
    cfg_wr(8, 2); cfg_wr(9, 1);
    req(0, 1, 0, 0, 0, 0, 1, "R8 one-shot first");
    req(0, 1, 0, 0, 0, 0, 1, "R8 one-shot second");
    rd_chk(9, 0, "R8 enable cleared");
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d left expected 0", q.size());
    end
    finish_run();
  end
endmodule